// File: doc/BRIEF.md
# Dual-Bank Data RAM Address Generator

This block feeds a small DSP datapath with two operands per cycle. It holds two data RAM banks of 256 words by 16 bits. Each bank has its own file of four 8-bit address pointers. In every cycle, each bank port picks one of its pointers and a modify mode. The picked pointer's current value addresses that bank's RAM. The pointer can then step up or down by one as a side effect of the access, so a loop can walk a buffer with no extra instructions. Both banks are addressed in the same cycle, which lets one operand from each bank reach a multiplier together.

A host-side load port writes any one of the eight pointers directly. A peek port reads any one of them back. Pointer arithmetic wraps modulo 256. Each bank also has a write port. Data words are treated as 16-bit two's complement values, but the block only stores them and never interprets them. Instruction decode, the multiplier and the accumulator sit outside this block.

Top module: `dual_bank_agu`

## Requirements
- R1: While reset is asserted (rstN low), all eight pointers clear to 0x00. After reset, both address outputs read 0x00 and every pointer peeks as 0x00.
- R2: Each bank's address output combinationally equals the pointer picked by that bank's select. This is the value before the current cycle's modify, and any modify becomes visible from the next cycle.
- R3: Mode 2'b01 post-increments the picked pointer by one, modulo 256, so 0xFF becomes 0x00.
- R4: Mode 2'b10 post-decrements the picked pointer by one, modulo 256, so 0x00 becomes 0xFF.
- R5: Mode 2'b00 (hold) and mode 2'b11 (reserved) leave the picked pointer unchanged.
- R6: Only the picked pointer of a bank can be auto-modified. The other three pointers of that bank, and every pointer of the other bank, are not touched by that bank's port.
- R7: With ldEn high, the pointer named by ldBank (0 or 1) and ldSel takes ldVal at the clock edge. This load wins over an auto-modify of the same pointer in the same cycle, while auto-modifies of other pointers still take place.
- R8: With a bank's write enable high, the write data is stored at that bank's current address at the clock edge.
- R9: Each bank's read data shows, one clock after an address is presented, the word held at that address before any write in that same cycle. Both banks deliver in the same cycle.
- R10: peekVal combinationally shows the pointer named by peekBank and peekSel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sel0 | input | 2 | Bank 0 pointer select |
| mode0 | input | 2 | Bank 0 modify mode (00 hold, 01 inc, 10 dec, 11 hold) |
| we0 | input | 1 | Bank 0 write enable |
| wdata0 | input | 16 | Bank 0 write data |
| addr0 | output | 8 | Bank 0 RAM address |
| rdata0 | output | 16 | Bank 0 read data (one-cycle latency) |
| sel1 | input | 2 | Bank 1 pointer select |
| mode1 | input | 2 | Bank 1 modify mode |
| we1 | input | 1 | Bank 1 write enable |
| wdata1 | input | 16 | Bank 1 write data |
| addr1 | output | 8 | Bank 1 RAM address |
| rdata1 | output | 16 | Bank 1 read data (one-cycle latency) |
| ldEn | input | 1 | Host pointer load strobe |
| ldBank | input | 1 | Bank of the pointer to load |
| ldSel | input | 2 | Index of the pointer to load |
| ldVal | input | 8 | Value to load |
| peekBank | input | 1 | Bank of the pointer to observe |
| peekSel | input | 2 | Index of the pointer to observe |
| peekVal | output | 8 | Observed pointer value |

## Verification
The address outputs and peekVal are combinational, so the bench checks them in the same cycle the selects are driven, a little after the inputs settle and before the clock edge. Pointer modifies and loads take effect at the next edge. The bench therefore walks peekVal across all eight pointers shortly after that edge and compares each one with its own arithmetic model. Read data arrives exactly one edge after its address. The bench captures the expected word from its memory model before applying that cycle's write, and compares it right after the following edge, so a read-before-write on the same address is judged correctly.

// File: rtl/agu_pkg.sv
`timescale 1ns/1ps
package agu_pkg;
  localparam int BANKS  = 2;
  localparam int PTRS   = 4;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int PSEL_W = $clog2(PTRS);
  localparam int BANK_W = $clog2(BANKS);
  localparam int DEPTH  = 1 << ADDR_W;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_INC  = 2'b01,
    MODE_DEC  = 2'b10,
    MODE_RSVD = 2'b11
  } mode_e;

  // per-pointer strobes from control to datapath
  typedef struct packed {
    logic [BANKS-1:0][PTRS-1:0] inc;
    logic [BANKS-1:0][PTRS-1:0] dec;
    logic [BANKS-1:0][PTRS-1:0] load;
  } ptr_strobe_t;
endpackage

// File: rtl/agu_ctrl.sv
`timescale 1ns/1ps
module agu_ctrl
  import agu_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [BANKS-1:0][PSEL_W-1:0]     selV,
  input  logic [BANKS-1:0][1:0]            modeV,
  input  logic                             ldEn,
  input  logic [BANK_W-1:0]                ldBank,
  input  logic [PSEL_W-1:0]                ldSel,
  output ptr_strobe_t                      stb
);

  always_comb begin
    stb = '0;
    for (int b = 0; b < BANKS; b++) begin
      for (int p = 0; p < PTRS; p++) begin
        stb.load[b][p] = ldEn && (ldBank == BANK_W'(b)) && (ldSel == PSEL_W'(p));
        if (!stb.load[b][p] && (selV[b] == PSEL_W'(p))) begin
          stb.inc[b][p] = (modeV[b] == MODE_INC);
          stb.dec[b][p] = (modeV[b] == MODE_DEC);
        end
      end
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bankChk
    // R6: at most one pointer of a bank is auto-modified per cycle
    a_r6_single_ptr: assert property (@(posedge clk) disable iff (!rstN)
      $countones(stb.inc[b] | stb.dec[b]) <= 1);
    for (genvar p = 0; p < PTRS; p++) begin : g_ptrChk
      // R7: a load excludes any auto-modify of the same pointer
      a_r7_load_excl: assert property (@(posedge clk) disable iff (!rstN)
        $onehot0({stb.inc[b][p], stb.dec[b][p], stb.load[b][p]}));
    end
  end

endmodule

// File: rtl/agu_dpath.sv
`timescale 1ns/1ps
module agu_dpath
  import agu_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  ptr_strobe_t                      stb,
  input  logic [BANKS-1:0][PSEL_W-1:0]     selV,
  input  logic [ADDR_W-1:0]                ldVal,
  input  logic [BANKS-1:0]                 weV,
  input  logic [BANKS-1:0][DATA_W-1:0]     wdataV,
  input  logic [BANK_W-1:0]                peekBank,
  input  logic [PSEL_W-1:0]                peekSel,
  output logic [BANKS-1:0][ADDR_W-1:0]     addrV,
  output logic [BANKS-1:0][DATA_W-1:0]     rdataV,
  output logic [ADDR_W-1:0]                peekVal
);

  logic [BANKS-1:0][PTRS-1:0][ADDR_W-1:0] ptrQ;

  always_ff @(posedge clk) begin
    for (int b = 0; b < BANKS; b++) begin
      for (int p = 0; p < PTRS; p++) begin
        if (!rstN)                ptrQ[b][p] <= '0;
        else if (stb.load[b][p])  ptrQ[b][p] <= ldVal;
        else if (stb.inc[b][p])   ptrQ[b][p] <= ptrQ[b][p] + 1'b1;
        else if (stb.dec[b][p])   ptrQ[b][p] <= ptrQ[b][p] - 1'b1;
      end
    end
  end

  always_comb begin
    for (int b = 0; b < BANKS; b++) addrV[b] = ptrQ[b][selV[b]];
  end

  assign peekVal = ptrQ[peekBank][peekSel];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdQ;

    always_ff @(posedge clk) begin
      if (weV[b]) mem[addrV[b]] <= wdataV[b];
    end

    always_ff @(posedge clk) begin
      if (!rstN) rdQ <= '0;
      else       rdQ <= mem[addrV[b]];
    end

    assign rdataV[b] = rdQ;

    // R8: a written word is present at its address after the edge
    a_r8_write: assert property (@(posedge clk) disable iff (!rstN)
      weV[b] |=> mem[$past(addrV[b])] == $past(wdataV[b]));

    for (genvar p = 0; p < PTRS; p++) begin : g_ptr
      // R3: post-increment wraps modulo 256
      a_r3_inc: assert property (@(posedge clk) disable iff (!rstN)
        stb.inc[b][p] |=> ptrQ[b][p] == ADDR_W'($past(ptrQ[b][p]) + 1'b1));
      // R4: post-decrement wraps modulo 256
      a_r4_dec: assert property (@(posedge clk) disable iff (!rstN)
        stb.dec[b][p] |=> ptrQ[b][p] == ADDR_W'($past(ptrQ[b][p]) - 1'b1));
      // R5: no strobe keeps the pointer
      a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
        !(stb.inc[b][p] || stb.dec[b][p] || stb.load[b][p]) |=> $stable(ptrQ[b][p]));
      // R7: load value wins
      a_r7_load: assert property (@(posedge clk) disable iff (!rstN)
        stb.load[b][p] |=> ptrQ[b][p] == $past(ldVal));
    end
  end

endmodule

// File: rtl/dual_bank_agu.sv
`timescale 1ns/1ps
module dual_bank_agu
  import agu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PSEL_W-1:0]    sel0,
  input  logic [1:0]           mode0,
  input  logic                 we0,
  input  logic [DATA_W-1:0]    wdata0,
  output logic [ADDR_W-1:0]    addr0,
  output logic [DATA_W-1:0]    rdata0,
  input  logic [PSEL_W-1:0]    sel1,
  input  logic [1:0]           mode1,
  input  logic                 we1,
  input  logic [DATA_W-1:0]    wdata1,
  output logic [ADDR_W-1:0]    addr1,
  output logic [DATA_W-1:0]    rdata1,
  input  logic                 ldEn,
  input  logic [BANK_W-1:0]    ldBank,
  input  logic [PSEL_W-1:0]    ldSel,
  input  logic [ADDR_W-1:0]    ldVal,
  input  logic [BANK_W-1:0]    peekBank,
  input  logic [PSEL_W-1:0]    peekSel,
  output logic [ADDR_W-1:0]    peekVal
);

  logic [BANKS-1:0][PSEL_W-1:0] selV;
  logic [BANKS-1:0][1:0]        modeV;
  logic [BANKS-1:0]             weV;
  logic [BANKS-1:0][DATA_W-1:0] wdataV;
  logic [BANKS-1:0][ADDR_W-1:0] addrV;
  logic [BANKS-1:0][DATA_W-1:0] rdataV;
  ptr_strobe_t                  stb;

  assign selV   = {sel1, sel0};
  assign modeV  = {mode1, mode0};
  assign weV    = {we1, we0};
  assign wdataV = {wdata1, wdata0};
  assign addr0  = addrV[0];
  assign addr1  = addrV[1];
  assign rdata0 = rdataV[0];
  assign rdata1 = rdataV[1];

  agu_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .selV(selV), .modeV(modeV),
    .ldEn(ldEn), .ldBank(ldBank), .ldSel(ldSel), .stb(stb)
  );

  agu_dpath i_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .selV(selV), .ldVal(ldVal),
    .weV(weV), .wdataV(wdataV), .peekBank(peekBank), .peekSel(peekSel),
    .addrV(addrV), .rdataV(rdataV), .peekVal(peekVal)
  );

endmodule

// File: tb/test_dual_bank_agu.sv
`timescale 1ns/1ps
module test_dual_bank_agu;
  import agu_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN = 1'b0;
  logic [1:0]  selB  [2];
  logic [1:0]  modeB [2];
  logic        weB   [2];
  logic [15:0] wdB   [2];
  logic        ldEn = 1'b0, ldBank = 1'b0, peekBank = 1'b0;
  logic [1:0]  ldSel = '0, peekSel = '0;
  logic [7:0]  ldVal = '0;
  logic [7:0]  addr0, addr1, peekVal;
  logic [15:0] rdata0, rdata1;

  logic [7:0]  ptrM   [2][4];
  logic [15:0] memM   [2][256];
  bit          knownM [2][256];
  int total = 0, bad = 0;

  dual_bank_agu i_dual_bank_agu (
    .clk(clk), .rstN(rstN),
    .sel0(selB[0]), .mode0(modeB[0]), .we0(weB[0]), .wdata0(wdB[0]), .addr0(addr0), .rdata0(rdata0),
    .sel1(selB[1]), .mode1(modeB[1]), .we1(weB[1]), .wdata1(wdB[1]), .addr1(addr1), .rdata1(rdata1),
    .ldEn(ldEn), .ldBank(ldBank), .ldSel(ldSel), .ldVal(ldVal),
    .peekBank(peekBank), .peekSel(peekSel), .peekVal(peekVal)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] pat(input int b, input int a, input int salt);
    return 16'(a * 257) ^ (b != 0 ? 16'h5AA5 : 16'hC33C) ^ 16'(salt);
  endfunction

  // walk peek over all pointers, compare with model
  task automatic peekAll(input string tags [2][4]);
    for (int b = 0; b < 2; b++)
      for (int p = 0; p < 4; p++) begin
        peekBank = b[0]; peekSel = p[1:0];
        #0.1;
        chk({tags[b][p], " R10 ptr"}, peekVal, ptrM[b][p]);
      end
  endtask

  // one clock: called at posedge+~1..2ns with inputs already driven
  task automatic doCycle();
    logic [15:0] expRd [2];
    bit          expKn [2];
    logic [7:0]  a    [2];
    string       tags [2][4];
    #1;
    a[0] = addr0; a[1] = addr1;
    for (int b = 0; b < 2; b++) begin
      chk("R2 addr", a[b], ptrM[b][selB[b]]);
      expRd[b] = memM[b][ptrM[b][selB[b]]];
      expKn[b] = knownM[b][ptrM[b][selB[b]]];
    end
    @(posedge clk); #1;
    for (int b = 0; b < 2; b++) begin
      logic [7:0] ad = ptrM[b][selB[b]];
      if (weB[b]) begin memM[b][ad] = wdB[b]; knownM[b][ad] = 1'b1; end
      for (int p = 0; p < 4; p++) begin
        if (ldEn && ldBank == b[0] && ldSel == p[1:0]) begin
          ptrM[b][p] = ldVal; tags[b][p] = "R7";
        end else if (selB[b] == p[1:0]) begin
          case (modeB[b])
            2'b01:   begin ptrM[b][p] = ptrM[b][p] + 8'd1; tags[b][p] = "R3"; end
            2'b10:   begin ptrM[b][p] = ptrM[b][p] - 8'd1; tags[b][p] = "R4"; end
            default: tags[b][p] = "R5";
          endcase
        end else tags[b][p] = "R6";
      end
    end
    if (expKn[0]) chk("R8 R9 rdata0", rdata0, expRd[0]);
    if (expKn[1]) chk("R8 R9 rdata1", rdata1, expRd[1]);
    peekAll(tags);
  endtask

  task automatic idle();
    for (int b = 0; b < 2; b++) begin selB[b] = 0; modeB[b] = 0; weB[b] = 0; wdB[b] = 0; end
    ldEn = 0;
  endtask

  task automatic loadPtr(input int b, input int p, input logic [7:0] v);
    idle();
    ldEn = 1; ldBank = b[0]; ldSel = p[1:0]; ldVal = v;
    doCycle();
    ldEn = 0;
  endtask

  initial begin
    string rtags [2][4];
    logic [7:0] seeds [8] = '{8'h00, 8'hFF, 8'h7F, 8'h80, 8'h01, 8'hFE, 8'h3C, 8'hC3};
    idle();
    for (int b = 0; b < 2; b++) begin
      for (int p = 0; p < 4; p++) begin ptrM[b][p] = '0; rtags[b][p] = "R1"; end
      for (int a = 0; a < 256; a++) begin memM[b][a] = '0; knownM[b][a] = 1'b0; end
    end
    repeat (3) @(posedge clk);
    #1; rstN = 1'b1;
    #0.5;
    chk("R1 addr0", addr0, 0);
    chk("R1 addr1", addr1, 0);
    peekAll(rtags);

    // R2..R7: every select/mode combination on both banks from varied seeds
    for (int pass = 0; pass < 2; pass++) begin
      for (int b = 0; b < 2; b++)
        for (int p = 0; p < 4; p++) loadPtr(b, p, seeds[(b*4 + p + pass*3) % 8]);
      for (int i = 0; i < 256; i++) begin
        selB[0] = i[1:0]; modeB[0] = i[3:2]; selB[1] = i[5:4]; modeB[1] = i[7:6];
        doCycle();
      end
    end

    // R7: load against auto-modify of same and of another pointer
    for (int m = 0; m < 4; m++)
      for (int b = 0; b < 2; b++) begin
        loadPtr(0, 2, 8'hFF); loadPtr(1, 2, 8'h00);
        selB[0] = 2; selB[1] = 2; modeB[0] = m[1:0]; modeB[1] = 2'(3 - m);
        ldEn = 1; ldBank = b[0]; ldSel = 2; ldVal = 8'h55 + 8'(m);
        doCycle();
        ldEn = 1; ldBank = b[0]; ldSel = 1; ldVal = 8'hA0;
        doCycle();
        ldEn = 0;
      end

    // R8: fill bank 0 upward from 0x00, bank 1 downward from 0xFF
    loadPtr(0, 3, 8'h00); loadPtr(1, 1, 8'hFF);
    for (int i = 0; i < 256; i++) begin
      selB[0] = 3; modeB[0] = 2'b01; weB[0] = 1; wdB[0] = pat(0, i, 0);
      selB[1] = 1; modeB[1] = 2'b10; weB[1] = 1; wdB[1] = pat(1, 255 - i, 0);
      doCycle();
    end

    // R9: read both banks back in the opposite direction
    idle();
    loadPtr(0, 0, 8'hFF); loadPtr(1, 3, 8'h00);
    for (int i = 0; i < 258; i++) begin
      selB[0] = 0; modeB[0] = 2'b10; selB[1] = 3; modeB[1] = 2'b11;
      if (i % 2 == 0) modeB[1] = 2'b01;
      doCycle();
    end

    // R9: read-before-write on the same address, then readback
    for (int i = 0; i < 6; i++) begin
      selB[0] = 1; modeB[0] = 2'b00; weB[0] = (i < 3); wdB[0] = pat(0, 7, i + 1);
      selB[1] = 0; modeB[1] = 2'b00; weB[1] = (i % 2 == 0); wdB[1] = pat(1, 9, i + 5);
      doCycle();
    end
    idle();
    doCycle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200us;
    bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule